// File: doc/BRIEF.md
# Channelized two-master SRAM arbiter

This block owns a 512-byte single-port SRAM, split into two 256-byte pages, and shares it between a CPU register port and a USB serial engine. Neither master addresses the array directly. Every access goes through one of sixteen logical channels. Each channel holds an 8-bit read pointer, an 8-bit write pointer and a data window. A transfer through the data window uses the channel's pointer, then advances that pointer, and the pointer wraps inside the channel's page. Channels 0 to 7 address page 0 and channels 8 to 15 address page 1.

The CPU can reach all sixteen channels. The USB engine names one of its eight non-control endpoints, and each endpoint is tied to one fixed channel. If the CPU wants to look at an endpoint's buffer, it points a second channel at the same bytes. Nothing in hardware stops the CPU from using a channel that an endpoint owns. The array keeps its contents through reset, so its contents are unknown after power-up. The pointers and the read-data registers do reset.

Top module: `chan_sram_arb`

## Requirements
- R1: After reset every read and write pointer is 0, and cpu_rdata and usb_rdata are 0.
- R2: An accepted CPU write with cpu_sel=0 stores cpu_wdata at byte {page, write pointer} of the selected channel, then increments that write pointer by one.
- R3: An accepted CPU read with cpu_sel=0 puts the byte at {page, read pointer} on cpu_rdata after the next rising edge, then increments that read pointer. cpu_rdata keeps its value until the next accepted CPU read.
- R4: cpu_sel=1 selects the read pointer and cpu_sel=2 selects the write pointer. A write loads the pointer from cpu_wdata. A read returns the pointer on cpu_rdata after the next rising edge.
- R5: A pointer increments from 255 to 0 and stays inside its channel's page.
- R6: Channels 0 to 7 address bytes 0 to 255 (page 0) and channels 8 to 15 address bytes 256 to 511 (page 1). Two channels of the same page whose pointers are equal reach the same byte.
- R7: USB endpoint index e (0 to 7) uses channel e+1 when e<4 and channel e+5 otherwise. A USB write or read acts like a CPU data access on that channel, and usb_rdata is valid after the next rising edge. The CPU sees the pointer movement this causes.
- R8: When cpu_req and usb_req are both high, the USB access is performed and cpu_wait is high. The CPU access then has no effect. The CPU access is performed in the first cycle with usb_req low, and cpu_wait is low whenever usb_req is low.
- R9: cpu_sel=3 is reserved. A write to it changes no pointer and no stored byte, and a read from it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held while cpu_wait is high |
| cpu_we | input | 1 | CPU access is a write |
| cpu_chan | input | 4 | CPU channel number |
| cpu_sel | input | 2 | Channel register: 0 data, 1 read pointer, 2 write pointer, 3 reserved |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wait | output | 1 | CPU request stalled this cycle |
| cpu_rdata | output | 8 | CPU read data, one cycle after acceptance |
| usb_req | input | 1 | USB engine data access request, always served |
| usb_we | input | 1 | USB access is a write |
| usb_ep | input | 3 | Endpoint index 0 to 7 |
| usb_wdata | input | 8 | USB write data |
| usb_rdata | output | 8 | USB read data, one cycle after the access |

## Verification
A wrong pointer in this block has two visible effects. The next data-window read returns a byte from the wrong address, and the next pointer readback differs, both one cycle after the access. The bench keeps its own model of the array and the pointers, so each of these readbacks is compared in the cycle it appears.

A page or wrap error shows up as data leaking between channels of different pages. A wrong endpoint map shows up as a CPU channel that does not see the endpoint's data. An arbitration fault shows up two ways: cpu_wait is wrong in the same cycle, or the CPU access is lost or doubled, which shows as a pointer off by one on the next readback.

// File: rtl/chan_sram_arb.sv
module chan_sram_arb #(
  parameter int DW  = 8,
  parameter int PAW = 8,
  parameter int NPG = 2,
  parameter int CPP = 8,
  parameter int NEP = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [$clog2(NPG*CPP)-1:0] cpu_chan,
  input  logic [1:0]             cpu_sel,
  input  logic [DW-1:0]          cpu_wdata,
  output logic                   cpu_wait,
  output logic [DW-1:0]          cpu_rdata,
  input  logic                   usb_req,
  input  logic                   usb_we,
  input  logic [$clog2(NEP)-1:0] usb_ep,
  input  logic [DW-1:0]          usb_wdata,
  output logic [DW-1:0]          usb_rdata
);
  localparam int NCH   = NPG * CPP;
  localparam int CW    = $clog2(NCH);
  localparam int PGW   = $clog2(NPG);
  localparam int AW    = PAW + PGW;
  localparam int DEPTH = 1 << AW;
  localparam int EPW   = $clog2(NEP);
  localparam int EPP   = NEP / NPG;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_RPTR = 2'd1;
  localparam logic [1:0] SEL_WPTR = 2'd2;

  function automatic logic [CW-1:0] ep_chan(input logic [EPW-1:0] e);
    return CW'((int'(e) / EPP) * CPP + (int'(e) % EPP) + 1);
  endfunction

  function automatic logic [PGW-1:0] page_of(input logic [CW-1:0] ch);
    return PGW'(int'(ch) / CPP);
  endfunction

  logic [NCH-1:0][PAW-1:0] wa_q, ra_q;
  logic [DW-1:0] mem [DEPTH];

  wire cpu_go = cpu_req & ~usb_req;
  assign cpu_wait = cpu_req & usb_req;

  wire            acc_data = usb_req | (cpu_go & (cpu_sel == SEL_DATA));
  wire            acc_we   = usb_req ? usb_we : cpu_we;
  wire [CW-1:0]   acc_ch   = usb_req ? ep_chan(usb_ep) : cpu_chan;
  wire [DW-1:0]   acc_wd   = usb_req ? usb_wdata : cpu_wdata;
  wire [PAW-1:0]  acc_ptr  = acc_we ? wa_q[acc_ch] : ra_q[acc_ch];
  wire [AW-1:0]   acc_addr = {page_of(acc_ch), acc_ptr};

  always_ff @(posedge clk)
    if (acc_data && acc_we) mem[acc_addr] <= acc_wd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        wa_q[i] <= '0;
        ra_q[i] <= '0;
      end
    end else begin
      if (acc_data) begin
        if (acc_we) wa_q[acc_ch] <= wa_q[acc_ch] + 1'b1;
        else        ra_q[acc_ch] <= ra_q[acc_ch] + 1'b1;
      end
      if (cpu_go && cpu_we) begin
        case (cpu_sel)
          SEL_RPTR: ra_q[cpu_chan] <= PAW'(cpu_wdata);
          SEL_WPTR: wa_q[cpu_chan] <= PAW'(cpu_wdata);
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
      usb_rdata <= '0;
    end else begin
      if (usb_req && !usb_we) usb_rdata <= mem[acc_addr];
      if (cpu_go && !cpu_we) begin
        case (cpu_sel)
          SEL_DATA: cpu_rdata <= mem[acc_addr];
          SEL_RPTR: cpu_rdata <= DW'(ra_q[cpu_chan]);
          SEL_WPTR: cpu_rdata <= DW'(wa_q[cpu_chan]);
          default:  cpu_rdata <= '0;
        endcase
      end
    end
  end
endmodule

module chan_sram_arb_chk #(
  parameter int PAW = 8,
  parameter int NCH = 16,
  parameter int CW  = 4,
  parameter int EPW = 3,
  parameter int CPP = 8,
  parameter int EPP = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cpu_req,
  input logic                    cpu_we,
  input logic [CW-1:0]           cpu_chan,
  input logic [1:0]              cpu_sel,
  input logic                    cpu_wait,
  input logic                    usb_req,
  input logic                    usb_we,
  input logic [EPW-1:0]          usb_ep,
  input logic [NCH-1:0][PAW-1:0] wa_q,
  input logic [NCH-1:0][PAW-1:0] ra_q
);
  logic           t_hit, t_usb, t_w;
  logic [CW-1:0]  t_ch;
  logic [PAW-1:0] t_ptr;
  logic [CW-1:0]  u_ch;

  assign u_ch = CW'((int'(usb_ep) / EPP) * CPP + (int'(usb_ep) % EPP) + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_hit <= 1'b0; t_usb <= 1'b0; t_w <= 1'b0; t_ch <= '0; t_ptr <= '0;
    end else if (usb_req) begin
      t_hit <= 1'b1; t_usb <= 1'b1; t_w <= usb_we; t_ch <= u_ch;
      t_ptr <= usb_we ? wa_q[u_ch] : ra_q[u_ch];
    end else begin
      t_hit <= cpu_req && cpu_sel == 2'd0; t_usb <= 1'b0; t_w <= cpu_we; t_ch <= cpu_chan;
      t_ptr <= cpu_we ? wa_q[cpu_chan] : ra_q[cpu_chan];
    end
  end

  // R2
  cpu_wr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_hit && !t_usb && t_w) |-> wa_q[t_ch] == PAW'(t_ptr + 1'b1));

  // R3
  cpu_rd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_hit && !t_usb && !t_w) |-> ra_q[t_ch] == PAW'(t_ptr + 1'b1));

  // R7
  usb_wr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_hit && t_usb && t_w) |-> wa_q[t_ch] == PAW'(t_ptr + 1'b1));

  // R7
  usb_rd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_hit && t_usb && !t_w) |-> ra_q[t_ch] == PAW'(t_ptr + 1'b1));

  // R8
  wait_needs_usb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> (cpu_req && usb_req));

  // R8
  free_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !usb_req) |-> !cpu_wait);

  // R9
  rsv_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !usb_req && cpu_we && cpu_sel == 2'd3) |=> ($stable(wa_q) && $stable(ra_q)));
endmodule

bind chan_sram_arb chan_sram_arb_chk #(
  .PAW(PAW), .NCH(NCH), .CW(CW), .EPW(EPW), .CPP(CPP), .EPP(EPP)
) u_chk (.*);

// File: tb/tb_chan_sram_arb.sv
`timescale 1ns/1ps
module tb_chan_sram_arb;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, usb_req = 0, usb_we = 0;
  logic [3:0] cpu_chan = 0;
  logic [1:0] cpu_sel = 0;
  logic [7:0] cpu_wdata = 0, usb_wdata = 0;
  logic [2:0] usb_ep = 0;
  logic cpu_wait;
  logic [7:0] cpu_rdata, usb_rdata;

  always #10 clk = ~clk;

  chan_sram_arb dut (.*);

  int checks = 0, failures = 0;
  logic [7:0] m_mem [512];
  bit         m_ok  [512];
  logic [7:0] m_ra [16], m_wa [16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ep2ch(input int e);
    return (e < 4) ? e + 1 : e + 5;
  endfunction

  task automatic model_data(input int ch, input bit we, input logic [7:0] d,
                            output bit known, output logic [7:0] exp);
    int a;
    known = 0; exp = 0;
    if (we) begin
      a = (ch / 8) * 256 + m_wa[ch];
      m_mem[a] = d; m_ok[a] = 1; m_wa[ch] = m_wa[ch] + 8'd1;
    end else begin
      a = (ch / 8) * 256 + m_ra[ch];
      known = m_ok[a]; exp = m_mem[a]; m_ra[ch] = m_ra[ch] + 8'd1;
    end
  endtask

  task automatic model_cpu(input int ch, input int sel, input bit we, input logic [7:0] d,
                           output bit known, output logic [7:0] exp);
    known = 0; exp = 0;
    case (sel)
      0: model_data(ch, we, d, known, exp);
      1: if (we) m_ra[ch] = d; else begin known = 1; exp = m_ra[ch]; end
      2: if (we) m_wa[ch] = d; else begin known = 1; exp = m_wa[ch]; end
      default: if (!we) begin known = 1; exp = 0; end
    endcase
  endtask

  task automatic run(input string tag, input bit c_en, input int ch, input int sel,
                     input bit c_we, input int c_d, input bit u_en, input int ep,
                     input bit u_we, input int u_d);
    bit kn; logic [7:0] ex;
    @(negedge clk);
    cpu_req = c_en; cpu_chan = 4'(ch); cpu_sel = 2'(sel); cpu_we = c_we; cpu_wdata = 8'(c_d);
    usb_req = u_en; usb_ep = 3'(ep); usb_we = u_we; usb_wdata = 8'(u_d);
    #1;
    if (c_en) chk(cpu_wait == u_en, "R8 wait", cpu_wait, u_en);
    @(posedge clk);
    @(negedge clk);
    if (u_en) begin
      model_data(ep2ch(ep), u_we, 8'(u_d), kn, ex);
      if (kn) chk(usb_rdata == ex, {tag, " usb"}, usb_rdata, ex);
      usb_req = 0;
      if (c_en) begin
        #1;
        chk(cpu_wait == 0, "R8 release", cpu_wait, 0);
        @(posedge clk);
        @(negedge clk);
      end
    end
    if (c_en) begin
      model_cpu(ch, sel, c_we, 8'(c_d), kn, ex);
      if (kn) chk(cpu_rdata == ex, tag, cpu_rdata, ex);
      cpu_req = 0;
    end
  endtask

  task automatic cw(input string t, input int ch, input int sel, input int d);
    run(t, 1, ch, sel, 1, d, 0, 0, 0, 0);
  endtask
  task automatic cr(input string t, input int ch, input int sel);
    run(t, 1, ch, sel, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic uw(input string t, input int ep, input int d);
    run(t, 0, 0, 0, 0, 0, 1, ep, 1, d);
  endtask
  task automatic ur(input string t, input int ep);
    run(t, 0, 0, 0, 0, 0, 1, ep, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) begin m_ok[i] = 0; m_mem[i] = 0; end
    for (int i = 0; i < 16; i++) begin m_ra[i] = 0; m_wa[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_rdata == 0, "R1 cpu_rdata", cpu_rdata, 0);
    chk(usb_rdata == 0, "R1 usb_rdata", usb_rdata, 0);
    cr("R1", 5, 1);
    cr("R1", 14, 2);
    cr("R1", 9, 1);

    cw("R4", 6, 1, 8'h5A); cr("R4", 6, 1);
    cw("R4", 6, 2, 8'hC3); cr("R4", 6, 2);

    cw("R2", 3, 2, 8'h10);
    cw("R2", 3, 0, 8'hA1); cw("R2", 3, 0, 8'hA2); cw("R2", 3, 0, 8'hA3);
    cr("R2", 3, 2);
    cw("R3", 3, 1, 8'h10);
    cr("R3", 3, 0); cr("R3", 3, 0); cr("R3", 3, 0);
    cr("R3", 3, 1);
    cr("R3", 3, 1);
    chk(cpu_rdata == 8'h13, "R3 hold", cpu_rdata, 8'h13);

    cw("R5", 0, 2, 255);
    cw("R5", 0, 0, 8'hE1); cw("R5", 0, 0, 8'hE2);
    cr("R5", 0, 2);
    cw("R5", 0, 1, 255);
    cr("R5", 0, 0); cr("R5", 0, 0);
    cr("R5", 0, 1);

    cw("R6", 8, 2, 0); cw("R6", 8, 0, 8'h77);
    cw("R6", 0, 1, 0); cr("R6", 0, 0);
    cw("R6", 15, 1, 0); cr("R6", 15, 0);
    cw("R6", 5, 1, 8'h10); cr("R6", 5, 0);

    uw("R7", 0, 8'h31); uw("R7", 0, 8'h32);
    cr("R7", 1, 2);
    cw("R7", 2, 1, 0); cr("R7", 2, 0); cr("R7", 2, 0);
    uw("R7", 4, 8'h41);
    cr("R7", 9, 2);
    cw("R7", 13, 2, 8'h40); cw("R7", 13, 0, 8'h99);
    cw("R7", 12, 1, 8'h40); ur("R7", 7);
    cr("R7", 12, 1);

    run("R8", 1, 1, 2, 0, 0, 1, 0, 1, 8'h33);
    run("R8", 1, 1, 0, 1, 8'h55, 1, 0, 1, 8'h34);
    cr("R8", 1, 2);
    cw("R8", 1, 1, 0);
    for (int i = 0; i < 5; i++) cr("R8", 1, 0);

    cw("R9", 6, 3, 8'hFF);
    cr("R9", 6, 3);
    cr("R9", 6, 1); cr("R9", 6, 2);

    for (int i = 0; i < 600; i++) begin
      int mode, ch, sel, ep;
      mode = $urandom_range(0, 9);
      ch = $urandom_range(0, 15);
      sel = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0;
      ep = $urandom_range(0, 7);
      if (mode < 6)
        run("R2 R3 random", 1, ch, sel, 1'($urandom_range(0, 1)), $urandom_range(0, 255), 0, 0, 0, 0);
      else if (mode < 8)
        run("R7 random", 0, 0, 0, 0, 0, 1, ep, 1'($urandom_range(0, 1)), $urandom_range(0, 255));
      else
        run("R8 random", 1, ch, sel, 1'($urandom_range(0, 1)), $urandom_range(0, 255),
            1, ep, 1'($urandom_range(0, 1)), $urandom_range(0, 255));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule